// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Controller

This block produces the interrupt request for a parallel I/O card built from two port groups. In each group one pin, bit 3 of that group's third port, is wired to the block as a source level. A rising edge on either source sets one shared pending flag, but only while interrupt generation is enabled. The pending flag drives the single interrupt line directly.

Software has no data path into the block. Enable, disable and acknowledge are all triggered by the bus access itself. Any read of the control offset turns generation off. A write of any value to the same offset turns it on. A write of any value to the acknowledge offset clears the pending request. The decoded offsets are parameters, with defaults 0xB (control) and 0xF (acknowledge) inside a 16-byte window. The source levels are asynchronous and are synchronized inside the block. The external reset is asserted asynchronously and released on the clock.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, irq_out is low and generation is disabled, so a source edge with no prior enable write leaves irq_out low.
- R2: While generation is enabled, a source level first sampled high at rising clock edge k (after being sampled low at edge k-1) drives irq_out high from edge k+2 on. Either of the two sources can do this.
- R3: A falling edge, or a level that stays high, never raises a request.
- R4: A read strobe with bus_addr equal to 0xB disables generation from the next edge on.
- R5: A write strobe with bus_addr equal to 0xB enables generation from the next edge on. The written value does not matter.
- R6: A write strobe with bus_addr equal to 0xF clears a pending request at that edge.
- R7: Reads of 0xF and accesses to any other offset have no effect on the request or on the enable state.
- R8: Edges detected while generation is disabled are dropped and do not appear after a later enable.
- R9: The disabling read at 0xB also clears the pending request, so irq_out is low after that edge.
- R10: If an acknowledge write and a qualifying edge fall on the same clock edge, the request stays pending.
- R11: Once high, irq_out stays high until an acknowledge or a disable clears it. Further edges and source changes do not lower it.
- R12: When read and write strobes are both asserted at offset 0xB in the same cycle, the disable takes priority.
- R13: An edge qualifies only if generation was already enabled before the edge that consumes it. An enable write on that same edge does not rescue it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_level | input | NUM_SRC (2) | Monitored pin levels, one per group, asynchronous |
| bus_addr | input | ADDR_W (4) | Offset within the register window |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| irq_out | output | 1 | Interrupt request, high while a request is pending |

## Verification
The assertions assume that bus_addr, bus_rd and bus_wr are synchronous to clk, and that each cycle with a strobe high counts as exactly one access. They also assume the strobes are held low for the two cycles in which the internal reset is still being released. The source levels may change at any time. The bench drives every input on the falling clock edge and keeps the strobes low through reset and the idle cycles that follow it. The random stimulus biases the address toward the two decoded offsets and sometimes asserts both strobes together, which covers the priority case.

// File: rtl/portirq_pkg.sv
package portirq_pkg;

  // Decoded side-effect commands for one bus cycle
  typedef struct packed {
    logic gen_off;  // read of control offset
    logic gen_on;   // write of control offset
    logic ack;      // write of acknowledge offset
  } bus_cmd_t;

endpackage

// File: rtl/portirq_rstsync.sv
module portirq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_no = pipe_q[STAGES-1];

endmodule

// File: rtl/portirq_sync.sv
module portirq_sync #(
  parameter int NUM_SRC = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] rise_o
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;
    logic              prev_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], src_i[i]};
      prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= prev_d;
      end
    end

    assign rise_o[i] = chain_q[STAGES-1] & ~prev_q;
  end

endmodule

// File: rtl/portirq_decode.sv
module portirq_decode
  import portirq_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 4'hB,
  parameter logic [ADDR_W-1:0] ACK_OFS  = 4'hF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output bus_cmd_t          cmd_o
);

  logic hit_ctrl;
  logic hit_ack;

  always_comb begin
    hit_ctrl      = (addr_i == CTRL_OFS);
    hit_ack       = (addr_i == ACK_OFS);
    cmd_o.gen_off = rd_i & hit_ctrl;
    cmd_o.gen_on  = wr_i & hit_ctrl;
    cmd_o.ack     = wr_i & hit_ack;
  end

endmodule

// File: rtl/portirq_core.sv
module portirq_core
  import portirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  bus_cmd_t cmd_i,
  input  logic     edge_any_i,
  output logic     gen_en_o,
  output logic     pend_o
);

  logic en_q, en_d;
  logic pend_q, pend_d;
  logic upd;

  // Next state: disable dominates, then edge over acknowledge
  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    if (cmd_i.gen_off) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end else begin
      if (cmd_i.gen_on) en_d = 1'b1;
      if (en_q && edge_any_i) pend_d = 1'b1;
      else if (cmd_i.ack)     pend_d = 1'b0;
    end
    upd = cmd_i.gen_off | cmd_i.gen_on | cmd_i.ack | edge_any_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (upd) begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign gen_en_o = en_q;
  assign pend_o   = pend_q;

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import portirq_pkg::*;
#(
  parameter int                NUM_SRC     = 2,
  parameter int                ADDR_W      = 4,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS    = 4'hB,
  parameter logic [ADDR_W-1:0] ACK_OFS     = 4'hF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  output logic               irq_out
);

  logic               rst_int_n;
  logic [NUM_SRC-1:0] rise;
  logic               edge_any;
  bus_cmd_t           cmd;
  logic               gen_en;
  logic               pend;

  portirq_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_int_n)
  );

  portirq_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .src_i  (src_level),
    .rise_o (rise)
  );

  assign edge_any = |rise;

  portirq_decode #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .ACK_OFS(ACK_OFS)) u_dec (
    .addr_i (bus_addr),
    .rd_i   (bus_rd),
    .wr_i   (bus_wr),
    .cmd_o  (cmd)
  );

  portirq_core u_core (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .cmd_i      (cmd),
    .edge_any_i (edge_any),
    .gen_en_o   (gen_en),
    .pend_o     (pend)
  );

  assign irq_out = pend;

endmodule

// File: rtl/portirq_chk.sv
module portirq_chk #(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 4'hB,
  parameter logic [ADDR_W-1:0] ACK_OFS  = 4'hF
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              gen_en,
  input logic              edge_any,
  input logic              irq_out
);

  a_r4_read_disables: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_addr == CTRL_OFS) |=> !gen_en);

  a_r5_write_enables: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && !bus_rd && bus_addr == CTRL_OFS) |=> gen_en);

  a_r9_disable_drops_irq: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_addr == CTRL_OFS) |=> !irq_out);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && bus_addr == ACK_OFS && !edge_any) |=> !irq_out);

  a_r10_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    (gen_en && edge_any && !(bus_rd && bus_addr == CTRL_OFS)) |=> irq_out);

  a_r8_no_rise_disabled: assert property (@(posedge clk) disable iff (!rst_ni)
    !gen_en |=> !$rose(irq_out));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_out && !(bus_rd && bus_addr == CTRL_OFS) && !(bus_wr && bus_addr == ACK_OFS))
      |=> irq_out);

endmodule

bind edge_irq_ctrl portirq_chk #(
  .ADDR_W   (ADDR_W),
  .CTRL_OFS (CTRL_OFS),
  .ACK_OFS  (ACK_OFS)
) u_chk (
  .clk      (clk),
  .rst_ni   (rst_int_n),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .gen_en   (gen_en),
  .edge_any (edge_any),
  .irq_out  (irq_out)
);

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] src;
  logic [3:0] addr;
  logic       rd, wr;
  logic       irq;

  int vecs  = 0;
  int fails = 0;
  bit done  = 1'b0;
  string cur_tag = "R1";

  // Reference model state
  logic [1:0] m_s1, m_s2, m_prev;
  logic       m_en, m_pend;

  always #5 clk = ~clk;

  edge_irq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_level (src),
    .bus_addr  (addr),
    .bus_rd    (rd),
    .bus_wr    (wr),
    .irq_out   (irq)
  );

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = 1'b0; m_pend = 1'b0;
  endtask

  // One clock edge of the required behaviour (R2..R13)
  task automatic model_step(input logic [1:0] s, input logic [3:0] a,
                            input logic r, input logic w);
    logic rise, off, on, ack;
    rise = |(m_s2 & ~m_prev);
    off  = r && (a == 4'hB);
    on   = w && (a == 4'hB);
    ack  = w && (a == 4'hF);
    if (off) begin
      m_pend = 1'b0;
      m_en   = 1'b0;
    end else begin
      if (m_en && rise) m_pend = 1'b1;
      else if (ack)     m_pend = 1'b0;
      if (on) m_en = 1'b1;
    end
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = s;
  endtask

  task automatic check(input logic exp, input string tag);
    vecs++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq_out actual %0b expected %0b at %0t", tag, irq, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic [3:0] a,
                      input logic r, input logic w);
    src = s; addr = a; rd = r; wr = w;
    @(posedge clk);
    #1;
    model_step(s, a, r, w);
    @(negedge clk);
    check(m_pend, cur_tag);
  endtask

  task automatic idle(input logic [1:0] s, input int n);
    for (int i = 0; i < n; i++) step(s, 4'h0, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src = '0; addr = '0; rd = 1'b0; wr = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    idle(2'b00, 4);
    check(1'b0, "R1");

    cur_tag = "R8";
    idle(2'b01, 4);
    check(1'b0, "R1");
    idle(2'b00, 2);

    cur_tag = "R5";
    step(2'b00, 4'hB, 1'b0, 1'b1);
    cur_tag = "R2";
    step(2'b01, 4'h0, 1'b0, 1'b0);
    check(1'b0, "R2");
    step(2'b01, 4'h0, 1'b0, 1'b0);
    check(1'b0, "R2");
    step(2'b01, 4'h0, 1'b0, 1'b0);
    check(1'b1, "R2");

    cur_tag = "R11";
    idle(2'b01, 3);
    idle(2'b00, 3);
    check(1'b1, "R11");

    cur_tag = "R7";
    step(2'b00, 4'hF, 1'b1, 1'b0);
    check(1'b1, "R7");
    step(2'b00, 4'h3, 1'b0, 1'b1);
    step(2'b00, 4'h5, 1'b1, 1'b0);
    check(1'b1, "R7");

    cur_tag = "R6";
    step(2'b00, 4'hF, 1'b0, 1'b1);
    check(1'b0, "R6");

    cur_tag = "R2";
    idle(2'b10, 3);
    check(1'b1, "R2");
    cur_tag = "R3";
    step(2'b10, 4'hF, 1'b0, 1'b1);
    idle(2'b10, 3);
    check(1'b0, "R3");
    idle(2'b00, 3);
    check(1'b0, "R3");

    cur_tag = "R9";
    idle(2'b01, 3);
    check(1'b1, "R9");
    step(2'b01, 4'hB, 1'b1, 1'b0);
    check(1'b0, "R9");
    cur_tag = "R4";
    idle(2'b00, 2);
    idle(2'b10, 4);
    check(1'b0, "R4");
    cur_tag = "R8";
    step(2'b10, 4'hB, 1'b0, 1'b1);
    idle(2'b10, 3);
    check(1'b0, "R8");

    cur_tag = "R10";
    idle(2'b00, 3);
    idle(2'b01, 3);
    check(1'b1, "R10");
    idle(2'b11, 2);
    step(2'b11, 4'hF, 1'b0, 1'b1);
    check(1'b1, "R10");
    step(2'b11, 4'hF, 1'b0, 1'b1);
    check(1'b0, "R6");

    cur_tag = "R12";
    idle(2'b00, 3);
    idle(2'b01, 3);
    check(1'b1, "R12");
    step(2'b01, 4'hB, 1'b1, 1'b1);
    check(1'b0, "R12");
    idle(2'b00, 3);
    idle(2'b01, 3);
    check(1'b0, "R12");

    cur_tag = "R13";
    idle(2'b00, 3);
    idle(2'b01, 2);
    step(2'b01, 4'hB, 1'b0, 1'b1);
    idle(2'b01, 2);
    check(1'b0, "R13");
    idle(2'b00, 3);
    step(2'b01, 4'h0, 1'b0, 1'b0);
    step(2'b01, 4'hB, 1'b0, 1'b1);
    step(2'b01, 4'h0, 1'b0, 1'b0);
    check(1'b1, "R13");

    // Random phase against the model (R2, R4..R12)
    cur_tag = "R2-model";
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] s;
      logic [3:0] a;
      logic r, w;
      s = src;
      if ($urandom % 6 == 0) s[0] = ~s[0];
      if ($urandom % 6 == 0) s[1] = ~s[1];
      case ($urandom % 4)
        0:       a = 4'hB;
        1:       a = 4'hF;
        default: a = 4'($urandom);
      endcase
      r = ($urandom % 12 == 0);
      w = ($urandom % 8 == 0);
      step(s, a, r, w);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule